// File: doc/BRIEF.md
# Pipeline Operand Forwarding and Hazard Control

This block is the purely combinational hazard logic of a five-stage in-order pipeline (fetch, decode with register read, execute, memory, write-back). Every instruction takes one clock in each stage. The block looks at the source registers of the instructions in decode and execute, and at the destinations and write enables of the two later stages. From these it selects, for each ALU operand, whether the value comes from the register file or is bypassed from a later stage. A result that the next one or two instructions need therefore reaches the ALU without a stall. A dependency three instructions back needs no bypass, because the register file is written in the first half of the cycle and read in the second.

A load followed at once by an instruction that reads its result cannot be covered by bypassing. For that case the block raises a one-cycle stall: the PC and the fetch/decode register hold, and a bubble with all control bits cleared enters the decode/execute register. Branches are resolved in decode and predicted not taken. When a branch is taken, the block flushes the one instruction that was fetched down the wrong path. The pipeline registers, the register file and the ALU sit outside the block.

Top module: `hazard_unit`

## Requirements
- R1: An ALU operand select is 2'b10 (bypass from the execute/memory register) when that stage's write enable is 1, its destination is nonzero and it equals the operand's source register in execute.
- R2: An ALU operand select is 2'b01 (bypass from the memory/write-back register) when that stage's write enable is 1, its destination is nonzero and equals the source, and R1 does not apply to that operand.
- R3: When both later stages match the same nonzero source with write enable 1, the select is 2'b10.
- R4: The select is 2'b00 (register file) when no later stage qualifies. This includes a source of register 0 and a matching stage whose write enable is 0.
- R5: A load-use stall (pc_hold_o, ifid_hold_o and idex_bubble_o all 1) is raised when the execute instruction is a load with a nonzero destination equal to either decode source register.
- R6: No stall is raised when the execute instruction is not a load, when its destination is register 0, or when neither decode source matches.
- R7: ifid_flush_o is 1 when a branch is taken in decode and no stall is raised.
- R8: During a stall, ifid_flush_o is 0 even if the branch-taken input is 1, so the branch is taken once the stall is over.
- R9: The two operand selects are computed independently, each from its own execute source register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs_i | input | REG_W | First source register of the instruction in execute |
| ex_rt_i | input | REG_W | Second source register of the instruction in execute |
| id_rs_i | input | REG_W | First source register of the instruction in decode |
| id_rt_i | input | REG_W | Second source register of the instruction in decode |
| ex_rd_i | input | REG_W | Destination register of the instruction in execute |
| ex_load_i | input | 1 | Instruction in execute reads data memory |
| mem_rd_i | input | REG_W | Destination register in the execute/memory register |
| mem_wr_i | input | 1 | Register write enable in the execute/memory register |
| wb_rd_i | input | REG_W | Destination register in the memory/write-back register |
| wb_wr_i | input | 1 | Register write enable in the memory/write-back register |
| br_taken_i | input | 1 | Branch in decode resolves taken |
| fwd_a_o | output | 2 | First ALU operand select (00 file, 10 exe/mem, 01 mem/wb) |
| fwd_b_o | output | 2 | Second ALU operand select, same encoding |
| pc_hold_o | output | 1 | Hold the PC this cycle |
| ifid_hold_o | output | 1 | Hold the fetch/decode register this cycle |
| idex_bubble_o | output | 1 | Load a bubble with all control bits cleared into decode/execute |
| ifid_flush_o | output | 1 | Replace the fetch/decode contents with a no-op |

## Verification
The assertions assume that every input is a settled, known value whenever the outputs are sampled. They also assume that a destination field carries meaning only together with its write enable or load flag. The block keeps no state, so these checks are plain implications between the current inputs and outputs. The bench uses a two-bit register field so that every combination can be swept. All inputs change together away from the clock edge and are held while the outputs are checked, so the checks never see an input that is still changing.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hazard_fwd_sel.sv
module hazard_fwd_sel
  import hazard_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src_i,
  input  logic [REG_W-1:0] mem_rd_i,
  input  logic             mem_wr_i,
  input  logic [REG_W-1:0] wb_rd_i,
  input  logic             wb_wr_i,
  output fwd_sel_e         sel_o
);
  logic src_live, hit_mem, hit_wb;

  assign src_live = |src_i;
  assign hit_mem  = src_live && mem_wr_i && (mem_rd_i == src_i);
  assign hit_wb   = src_live && wb_wr_i  && (wb_rd_i  == src_i);

  // younger result wins
  always_comb begin
    if (hit_mem)     sel_o = FWD_MEM;
    else if (hit_wb) sel_o = FWD_WB;
    else             sel_o = FWD_RF;
  end
endmodule

// File: rtl/hazard_load_use.sv
module hazard_load_use #(
  parameter int REG_W = 5,
  parameter int N_SRC = 2
) (
  input  logic [REG_W-1:0] id_src_i [N_SRC],
  input  logic [REG_W-1:0] ex_rd_i,
  input  logic             ex_load_i,
  output logic             stall_o
);
  logic [N_SRC-1:0] hit;

  for (genvar g = 0; g < N_SRC; g++) begin : g_cmp
    assign hit[g] = (id_src_i[g] == ex_rd_i);
  end

  assign stall_o = ex_load_i && (|ex_rd_i) && (|hit);
endmodule

// File: rtl/hazard_flush.sv
module hazard_flush (
  input  logic br_taken_i,
  input  logic stall_i,
  output logic flush_o
);
  // a stalled branch is re-evaluated next cycle
  assign flush_o = br_taken_i && !stall_i;
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
  import hazard_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] ex_rs_i,
  input  logic [REG_W-1:0] ex_rt_i,
  input  logic [REG_W-1:0] id_rs_i,
  input  logic [REG_W-1:0] id_rt_i,
  input  logic [REG_W-1:0] ex_rd_i,
  input  logic             ex_load_i,
  input  logic [REG_W-1:0] mem_rd_i,
  input  logic             mem_wr_i,
  input  logic [REG_W-1:0] wb_rd_i,
  input  logic             wb_wr_i,
  input  logic             br_taken_i,
  output logic [1:0]       fwd_a_o,
  output logic [1:0]       fwd_b_o,
  output logic             pc_hold_o,
  output logic             ifid_hold_o,
  output logic             idex_bubble_o,
  output logic             ifid_flush_o
);
  localparam int N_OPS = 2;

  logic [REG_W-1:0] ex_src [N_OPS];
  logic [REG_W-1:0] id_src [N_OPS];
  fwd_sel_e         sel    [N_OPS];
  logic             stall;

  assign ex_src[0] = ex_rs_i;
  assign ex_src[1] = ex_rt_i;
  assign id_src[0] = id_rs_i;
  assign id_src[1] = id_rt_i;

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    hazard_fwd_sel #(.REG_W(REG_W)) i_sel (
      .src_i    (ex_src[g]),
      .mem_rd_i (mem_rd_i),
      .mem_wr_i (mem_wr_i),
      .wb_rd_i  (wb_rd_i),
      .wb_wr_i  (wb_wr_i),
      .sel_o    (sel[g])
    );
  end

  assign fwd_a_o = sel[0];
  assign fwd_b_o = sel[1];

  hazard_load_use #(.REG_W(REG_W), .N_SRC(N_OPS)) i_lu (
    .id_src_i  (id_src),
    .ex_rd_i   (ex_rd_i),
    .ex_load_i (ex_load_i),
    .stall_o   (stall)
  );

  hazard_flush i_fl (
    .br_taken_i (br_taken_i),
    .stall_i    (stall),
    .flush_o    (ifid_flush_o)
  );

  assign pc_hold_o     = stall;
  assign ifid_hold_o   = stall;
  assign idex_bubble_o = stall;
endmodule

// File: rtl/hazard_unit_chk.sv
module hazard_unit_chk #(
  parameter int REG_W = 5
) (
  input logic [REG_W-1:0] ex_rs_i,
  input logic [REG_W-1:0] ex_rt_i,
  input logic [REG_W-1:0] id_rs_i,
  input logic [REG_W-1:0] id_rt_i,
  input logic [REG_W-1:0] ex_rd_i,
  input logic             ex_load_i,
  input logic [REG_W-1:0] mem_rd_i,
  input logic             mem_wr_i,
  input logic [REG_W-1:0] wb_rd_i,
  input logic             wb_wr_i,
  input logic             br_taken_i,
  input logic [1:0]       fwd_a_o,
  input logic [1:0]       fwd_b_o,
  input logic             pc_hold_o,
  input logic             ifid_hold_o,
  input logic             idex_bubble_o,
  input logic             ifid_flush_o
);
  always_comb begin
    // R1
    if (mem_wr_i && (|ex_rs_i) && mem_rd_i == ex_rs_i)
      fwd_mem_a_chk: assert (fwd_a_o == 2'b10);
    // R9
    if (mem_wr_i && (|ex_rt_i) && mem_rd_i == ex_rt_i)
      fwd_mem_b_chk: assert (fwd_b_o == 2'b10);
    // R2
    if (wb_wr_i && (|ex_rs_i) && wb_rd_i == ex_rs_i && !(mem_wr_i && mem_rd_i == ex_rs_i))
      fwd_wb_a_chk: assert (fwd_a_o == 2'b01);
    // R4
    if (ex_rs_i == '0)
      zero_src_chk: assert (fwd_a_o == 2'b00);
    // R5
    if (ex_load_i && (|ex_rd_i) && (ex_rd_i == id_rs_i || ex_rd_i == id_rt_i))
      load_use_chk: assert (pc_hold_o && ifid_hold_o && idex_bubble_o);
    // R6
    if (!ex_load_i || ex_rd_i == '0)
      no_stall_chk: assert (!pc_hold_o && !ifid_hold_o && !idex_bubble_o);
    // R7
    if (br_taken_i && !pc_hold_o)
      flush_chk: assert (ifid_flush_o);
    // R8
    flush_excl_chk: assert (!(ifid_flush_o && idex_bubble_o));
  end
endmodule

bind hazard_unit hazard_unit_chk #(.REG_W(REG_W)) i_chk (.*);

// File: tb/test_hazard_unit.sv
module test_hazard_unit;
  localparam int RW = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [RW-1:0] ex_rs, ex_rt, id_rs, id_rt, ex_rd, mem_rd, wb_rd;
  logic ex_load, mem_wr, wb_wr, br_taken;
  logic [1:0] fwd_a, fwd_b;
  logic pc_hold, ifid_hold, idex_bubble, ifid_flush;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  hazard_unit #(.REG_W(RW)) i_hazard_unit (
    .ex_rs_i(ex_rs), .ex_rt_i(ex_rt), .id_rs_i(id_rs), .id_rt_i(id_rt),
    .ex_rd_i(ex_rd), .ex_load_i(ex_load), .mem_rd_i(mem_rd), .mem_wr_i(mem_wr),
    .wb_rd_i(wb_rd), .wb_wr_i(wb_wr), .br_taken_i(br_taken),
    .fwd_a_o(fwd_a), .fwd_b_o(fwd_b), .pc_hold_o(pc_hold),
    .ifid_hold_o(ifid_hold), .idex_bubble_o(idex_bubble), .ifid_flush_o(ifid_flush)
  );

  function automatic logic [1:0] exp_sel(logic [RW-1:0] s);
    if (s != 0 && mem_wr && mem_rd == s) return 2'b10;
    if (s != 0 && wb_wr && wb_rd == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic string sel_req(logic [1:0] e, logic [RW-1:0] s);
    if (e == 2'b10) return (wb_wr && wb_rd == s) ? "R3" : "R1";
    if (e == 2'b01) return "R2";
    return "R4";
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    {ex_rs, ex_rt, id_rs, id_rt, ex_rd, mem_rd, wb_rd} = '0;
    {ex_load, mem_wr, wb_wr, br_taken} = '0;
    @(posedge clk); #1;
    // reset-state style idle check: all outputs quiet
    chk("R4 idle fwd_a", fwd_a, 0);
    chk("R4 idle fwd_b", fwd_b, 0);
    chk("R6 idle stall", pc_hold, 0);
    chk("R7 idle flush", ifid_flush, 0);

    // forwarding sweep: both operands (R1 R2 R3 R4 R9)
    for (int v = 0; v < 1024; v++) begin
      @(negedge clk);
      {ex_rs, ex_rt, mem_rd, mem_wr, wb_rd, wb_wr} = v[9:0];
      ex_load = 1'b0; br_taken = 1'b0;
      #1;
      chk({sel_req(exp_sel(ex_rs), ex_rs), " fwd_a"}, fwd_a, exp_sel(ex_rs));
      chk({sel_req(exp_sel(ex_rt), ex_rt), " R9 fwd_b"}, fwd_b, exp_sel(ex_rt));
    end

    // stall and flush sweep (R5 R6 R7 R8)
    mem_wr = 1'b0; wb_wr = 1'b0;
    for (int v = 0; v < 256; v++) begin
      logic es;
      logic ef;
      @(negedge clk);
      {id_rs, id_rt, ex_rd, ex_load, br_taken} = v[7:0];
      #1;
      es = ex_load && ex_rd != 0 && (ex_rd == id_rs || ex_rd == id_rt);
      ef = br_taken && !es;
      chk(es ? "R5 pc_hold" : "R6 pc_hold", pc_hold, es);
      chk(es ? "R5 ifid_hold" : "R6 ifid_hold", ifid_hold, es);
      chk(es ? "R5 idex_bubble" : "R6 idex_bubble", idex_bubble, es);
      chk(es ? "R8 flush" : "R7 flush", ifid_flush, ef);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule